// File: doc/BRIEF.md
# Boxed Single-Precision Sign-Injection Unit

This unit performs the three single-precision sign-injection operations on operands that live in 64-bit floating-point registers. A narrow value held in a wide register is valid only when it is NaN-boxed, meaning every bit above the 32-bit value is one. Each operand is therefore screened first. An operand that fails the screen is swapped for the boxed canonical quiet NaN before any sign bit is touched.

After screening, the unit keeps the exponent and mantissa of the first operand (bits 30:0). It then attaches a sign bit derived from the second operand: a copy of that operand's sign, its inverse, or the XOR of the two signs. Move, negate and absolute value are the same operations with both operands equal, so they need no separate path. The result and its valid flag are registered, and the result is always a properly boxed value. The unit raises no floating-point exception flags.

Top module: `sgnj_unit`

## Requirements
- R1: An operand whose bits 63:32 are all ones is used unchanged by the operation.
- R2: An operand with any zero in bits 63:32 is replaced by 64'hFFFF_FFFF_7FC0_0000 before the operation.
- R3: With op_i = 2'b00 (copy), res_o[30:0] comes from the screened first operand, and res_o[63:31] comes from the screened second operand.
- R4: With op_i = 2'b01 (flip), res_o[31] is the inverse of bit 31 of the screened second operand. All other bits come from the screened first operand.
- R5: With op_i = 2'b10 (mix), res_o[31] is the XOR of bit 31 of the two screened operands. All other bits come from the screened first operand.
- R6: op_i = 2'b11 is reserved. It yields 64'hFFFF_FFFF_7FC0_0000 with illegal_o = 1. Every other code yields illegal_o = 0.
- R7: Whenever res_valid_o is 1, res_o[63:31+1] (bits 63:32) are all ones.
- R8: res_valid_o is high exactly one clock after a cycle with in_valid_i high. A cycle with in_valid_i low leaves res_o unchanged.
- R9: While rst_i is high at a rising edge, the next state has res_valid_o = 0, res_o = 0 and illegal_o = 0.
- R10: When opa_i equals opb_i, the copy, flip and mix operations give move, negate and absolute value. These results are the same as the general formulas give, including the screening of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and op are presented this cycle |
| op_i | input | 2 | 00 copy, 01 flip, 10 mix, 11 reserved |
| opa_i | input | 64 | First operand (magnitude source) |
| opb_i | input | 64 | Second operand (sign source) |
| res_o | output | 64 | Registered boxed result |
| res_valid_o | output | 1 | Result valid, one cycle after in_valid_i |
| illegal_o | output | 1 | The reserved op code was used |

## Verification
Several properties are checked on every cycle:
- the result is always boxed;
- the output is valid exactly one cycle after the input;
- the result holds when no input arrives;
- the reserved code produces the canonical NaN and the illegal flag;
- the flip operation inverts the sign when both operands are boxed;
- a boxed first operand always supplies the low 31 bits.

Only the bench's sweeps can show the substitution of unboxed operands in every operation and in the copy sign path. The same holds for the mix truth table and for the equality of the equal-operand cases with the general formulas. These sweeps cross all four op codes with boxed, partially boxed and unboxed operands of both signs.

// File: rtl/sgnj_pkg.sv
package sgnj_pkg;
    localparam int WIDE_W = 64;
    localparam int NARR_W = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = NARR_W - 1 - EXP_W;
    localparam int PAD_W  = WIDE_W - NARR_W;
    localparam int SGN_B  = NARR_W - 1;

    localparam logic [NARR_W-1:0] QNAN_N = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0] QNAN_W = {{PAD_W{1'b1}}, QNAN_N};

    typedef enum logic [1:0] {
        SJ_COPY = 2'b00,
        SJ_FLIP = 2'b01,
        SJ_MIX  = 2'b10,
        SJ_RSVD = 2'b11
    } sj_op_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [WIDE_W-1:0] result;
    } sj_state_t;
endpackage

// File: rtl/sgnj_box_guard.sv
module sgnj_box_guard
    import sgnj_pkg::*;
#(
    parameter int W_WIDE = WIDE_W,
    parameter int W_NARR = NARR_W
) (
    input  logic [W_WIDE-1:0] raw_i,
    input  logic [W_WIDE-1:0] subst_i,
    output logic [W_WIDE-1:0] clean_o,
    output logic              boxed_o
);
    localparam int PAD = W_WIDE - W_NARR;

    always_comb begin
        boxed_o = &raw_i[W_WIDE-1:W_WIDE-PAD];
        clean_o = boxed_o ? raw_i : subst_i;
    end
endmodule

// File: rtl/sgnj_sign_core.sv
module sgnj_sign_core
    import sgnj_pkg::*;
#(
    parameter int W_WIDE = WIDE_W,
    parameter int SIGN   = SGN_B
) (
    input  sj_op_e            op_i,
    input  logic [W_WIDE-1:0] a_i,
    input  logic [W_WIDE-1:0] b_i,
    input  logic [W_WIDE-1:0] nan_i,
    output logic [W_WIDE-1:0] res_o,
    output logic              bad_op_o
);
    always_comb begin
        res_o    = a_i;
        bad_op_o = 1'b0;
        unique case (op_i)
            SJ_COPY: begin
                res_o           = b_i;
                res_o[SIGN-1:0] = a_i[SIGN-1:0];
            end
            SJ_FLIP: res_o[SIGN] = ~b_i[SIGN];
            SJ_MIX:  res_o[SIGN] = a_i[SIGN] ^ b_i[SIGN];
            default: begin
                res_o    = nan_i;
                bad_op_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sgnj_unit.sv
module sgnj_unit
    import sgnj_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [1:0]        op_i,
    input  logic [WIDE_W-1:0] opa_i,
    input  logic [WIDE_W-1:0] opb_i,
    output logic [WIDE_W-1:0] res_o,
    output logic              res_valid_o,
    output logic              illegal_o
);
    localparam int N_OPS = 2;

    logic [WIDE_W-1:0] raw   [N_OPS];
    logic [WIDE_W-1:0] clean [N_OPS];
    logic [N_OPS-1:0]  boxed;
    logic [WIDE_W-1:0] core_res;
    logic              core_bad;
    sj_state_t         st_d, st_q;

    assign raw[0] = opa_i;
    assign raw[1] = opb_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_guard
        sgnj_box_guard #(.W_WIDE(WIDE_W), .W_NARR(NARR_W)) u_guard (
            .raw_i   (raw[g]),
            .subst_i (QNAN_W),
            .clean_o (clean[g]),
            .boxed_o (boxed[g])
        );
    end

    sgnj_sign_core #(.W_WIDE(WIDE_W), .SIGN(SGN_B)) u_core (
        .op_i     (sj_op_e'(op_i)),
        .a_i      (clean[0]),
        .b_i      (clean[1]),
        .nan_i    (QNAN_W),
        .res_o    (core_res),
        .bad_op_o (core_bad)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            st_d.result  = core_res;
            st_d.illegal = core_bad;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign res_o       = st_q.result;
    assign res_valid_o = st_q.valid;
    assign illegal_o   = st_q.illegal;

    logic unused_boxed;
    assign unused_boxed = ^boxed;
endmodule

// File: rtl/sgnj_unit_chk.sv
module sgnj_unit_chk
    import sgnj_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              in_valid_i,
    input logic [1:0]        op_i,
    input logic [WIDE_W-1:0] opa_i,
    input logic [WIDE_W-1:0] opb_i,
    input logic [WIDE_W-1:0] res_o,
    input logic              res_valid_o,
    input logic              illegal_o
);
    logic a_box, b_box;
    assign a_box = &opa_i[WIDE_W-1:NARR_W];
    assign b_box = &opb_i[WIDE_W-1:NARR_W];

    AST_BOXED_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o |-> (&res_o[WIDE_W-1:NARR_W])); // R7
    AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> res_valid_o); // R8
    AST_IDLE_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> (!res_valid_o && $stable(res_o))); // R8
    AST_RSVD_NAN: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b11) |=> (illegal_o && res_o == QNAN_W)); // R6
    AST_LEGAL_OP: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i != 2'b11) |=> !illegal_o); // R6
    AST_FLIP_SIGN: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == 2'b01 && a_box && b_box) |=> (res_o[SGN_B] != $past(opb_i[SGN_B]))); // R4
    AST_LOW_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i != 2'b11 && a_box) |=> (res_o[SGN_B-1:0] == $past(opa_i[SGN_B-1:0]))); // R1
    AST_RESET_CLR: assert property (@(posedge clk_i)
        rst_i |=> (!res_valid_o && !illegal_o && res_o == '0)); // R9
endmodule

bind sgnj_unit sgnj_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .op_i        (op_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .illegal_o   (illegal_o)
);

// File: tb/sim_sgnj_unit.sv
module sim_sgnj_unit;
    localparam logic [63:0] CNAN = 64'hFFFF_FFFF_7FC0_0000;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [63:0] res_o;
    logic        res_valid_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    sgnj_unit u0 (
        .clk_i(clk_i), .rst_i(rst_i), .in_valid_i(in_valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .res_o(res_o),
        .res_valid_o(res_valid_o), .illegal_o(illegal_o)
    );

    always #10 clk_i = ~clk_i;

    function automatic logic [63:0] pick(int i);
        case (i)
            0: pick = 64'hFFFF_FFFF_3F80_0000;
            1: pick = 64'hFFFF_FFFF_C120_0000;
            2: pick = 64'hFFFF_FFFF_7FC0_0000;
            3: pick = 64'hFFFF_FFFF_8000_0001;
            4: pick = 64'h0000_0000_4049_0FDB;
            5: pick = 64'hFFFF_FFFE_BF80_0000;
            6: pick = 64'h7FFF_FFFF_FFFF_FFFF;
            default: pick = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] screen(logic [63:0] x);
        screen = (x[63:32] == 32'hFFFF_FFFF) ? x : CNAN;
    endfunction

    function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] sa, sb;
        sa = screen(a);
        sb = screen(b);
        case (op)
            2'b00: model = {sb[63:31], sa[30:0]};
            2'b01: model = {sa[63:32], ~sb[31], sa[30:0]};
            2'b10: model = {sa[63:32], sa[31] ^ sb[31], sa[30:0]};
            default: model = CNAN;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(logic [1:0] op, logic [63:0] a, logic [63:0] b, string req);
        @(negedge clk_i);
        in_valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        check(req, res_o, model(op, a, b));
        check("R8 valid", {63'd0, res_valid_o}, 64'd1);
        check("R6 illegal", {63'd0, illegal_o}, {63'd0, op == 2'b11});
        check("R7 boxed", {32'd0, res_o[63:32]}, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk_i);
        // R9 reset state
        check("R9 result", res_o, 64'd0);
        check("R9 valid", {63'd0, res_valid_o}, 64'd0);
        check("R9 illegal", {63'd0, illegal_o}, 64'd0);
        rst_i = 1'b0;

        // R1 R2 R3 R4 R5 R6 sweep over ops and operand pairs
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    apply(2'(op), pick(i), pick(j),
                          op == 0 ? "R3 copy" : op == 1 ? "R4 flip" : op == 2 ? "R5 mix" : "R6 rsvd");
                end
            end
        end

        // R1 boxed operand passes through copy unchanged
        apply(2'b00, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_0000_0000, "R1 pass");
        check("R1 value", res_o, 64'hFFFF_FFFF_1234_5678);
        // R2 unboxed operand becomes canonical NaN
        apply(2'b00, 64'h0000_0001_1234_5678, 64'h0000_0000_0000_0000, "R2 subst");
        check("R2 value", res_o, CNAN);

        // R10 equal operands: move, negate, absolute value
        for (int i = 0; i < 8; i++) begin
            apply(2'b00, pick(i), pick(i), "R10 move");
            check("R10 move val", res_o, screen(pick(i)));
            apply(2'b01, pick(i), pick(i), "R10 neg");
            check("R10 neg val", res_o, screen(pick(i)) ^ 64'h0000_0000_8000_0000);
            apply(2'b10, pick(i), pick(i), "R10 abs");
            check("R10 abs val", res_o, screen(pick(i)) & ~64'h0000_0000_8000_0000);
        end

        // R8 hold while idle: inputs change without in_valid_i
        apply(2'b01, pick(0), pick(1), "R4 pre-hold");
        held = res_o;
        opa_i = pick(3); opb_i = pick(5); op_i = 2'b10;
        @(negedge clk_i);
        check("R8 hold", res_o, held);
        check("R8 idle valid", {63'd0, res_valid_o}, 64'd0);

        // R9 reset mid-run
        rst_i = 1'b1;
        @(negedge clk_i);
        check("R9 rerun result", res_o, 64'd0);
        check("R9 rerun valid", {63'd0, res_valid_o}, 64'd0);
        rst_i = 1'b0;

        finish_run();
    end
endmodule